// File: doc/BRIEF.md
# Sparse Negacyclic Polynomial Multiplier

This block forms the product of a small-coefficient secret polynomial and a sparse challenge polynomial in the ring of integer polynomials reduced by x^N + 1. The challenge has exactly KAPPA coefficients equal to one and is never stored densely. It arrives as a stream of KAPPA positions. For each position the block walks once over all N secret coefficients. It adds each coefficient into the accumulator slot that the rotation selects. When the rotation wraps past the top degree it subtracts instead, because x^N = -1. The run takes time in proportion to N times KAPPA and needs no transform.

The secret is loaded through a write port into an internal register file before a run. A start pulse first clears the accumulator bank. The block then takes positions one at a time through a valid/ready handshake. After the last pass it raises done, and the signed result can be read combinationally through a read port. Coefficients are not reduced modulo any prime, so the accumulators are sized to hold KAPPA worst-case terms exactly.

Top module: `spm_negacyclic_mul`

## Requirements
- R1: While reset is held, and after it is released with no start, busy, done and idx_ready are all 0.
- R2: A start pulse seen while the block is idle or done sets every one of the N accumulators to zero before the first position is used. A run therefore never carries results from an earlier run.
- R3: After a run with positions j_0..j_{KAPPA-1}, accumulator k holds the sum, over every position j and every secret index i, of +s[i] when i + j = k and of -s[i] when i + j = k + N.
- R4: A position that appears more than once in a run is applied once for each appearance.
- R5: idx_ready is 1 only while the block waits for the next position. Exactly one position is taken per pass over the secret and exactly KAPPA per run. No position is taken once done is 1.
- R6: With idx_valid held at 1, done first reads 1 exactly N + KAPPA*(N+1) clock edges after the edge that samples start. It stays 1 until the next start.
- R7: A secret write requested while busy is 1 is dropped and does not change the result.
- R8: A start pulse while busy is 1 is ignored, so the run keeps its timing and its result.
- R9: acc_rdata shows accumulator acc_raddr combinationally. While done is 1 the stored results do not change.
- R10: The accumulators are signed with SEC_W + ceil(log2(KAPPA+1)) bits. A run in which every term has the largest allowed magnitude of either sign yields exact values without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_we | input | 1 | Secret write strobe, taken only while idle or done |
| sec_waddr | input | IDX_W | Secret coefficient index to write |
| sec_wdata | input | SEC_W | Signed secret coefficient |
| start | input | 1 | Begins a run: clear, then KAPPA passes |
| idx_valid | input | 1 | A challenge position is offered |
| idx_data | input | IDX_W | Challenge position, 0..N-1 |
| idx_ready | output | 1 | The block takes the offered position on this edge |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last pass has finished and the result is valid |
| acc_raddr | input | IDX_W | Result coefficient to read |
| acc_rdata | output | ACC_W | Signed result coefficient, combinational from acc_raddr |

## Verification
The only result with fixed timing is done. With positions always offered it must first appear N + KAPPA*(N+1) edges after the start edge. The bench counts rising edges from that edge and tests done at each falling edge, so the first falling edge at which done is 1 gives the latency directly. idx_ready is a registered state decode, so the bench samples it at the falling edge and counts a handshake on the following rising edge. Result coefficients are combinational from the read address. The bench sets the address at a falling edge and samples one nanosecond later, compares the value with a dense negacyclic product computed in the bench, and repeats reads after idle cycles to confirm that the results hold.

// File: rtl/spm_pkg.sv
package spm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_FETCH = 3'd2,
    ST_MAC   = 3'd3,
    ST_DONE  = 3'd4
  } spm_state_e;

endpackage

// File: rtl/spm_sec_ram.sv
module spm_sec_ram #(
  parameter int N     = 512,
  parameter int IDX_W = 9,
  parameter int SEC_W = 4
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [IDX_W-1:0]        waddr,
  input  logic signed [SEC_W-1:0] wdata,
  input  logic [IDX_W-1:0]        raddr,
  output logic signed [SEC_W-1:0] rdata
);

  logic signed [SEC_W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/spm_acc_bank.sv
module spm_acc_bank #(
  parameter int N     = 512,
  parameter int IDX_W = 9,
  parameter int SEC_W = 4,
  parameter int ACC_W = 9
) (
  input  logic                    clk,
  input  logic                    clr_en,
  input  logic                    mac_en,
  input  logic                    neg,
  input  logic [IDX_W-1:0]        addr,
  input  logic signed [SEC_W-1:0] operand,
  input  logic [IDX_W-1:0]        raddr,
  output logic signed [ACC_W-1:0] rdata
);

  localparam int EXT_W = ACC_W - SEC_W;

  logic signed [ACC_W-1:0] mem [N];
  logic signed [ACC_W-1:0] op_ext;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] upd;

  // sign-extend, then fold the x^N = -1 wrap into a negation
  assign op_ext = {{EXT_W{operand[SEC_W-1]}}, operand};
  assign term   = neg ? -op_ext : op_ext;
  assign upd    = mem[addr] + term;

  always_ff @(posedge clk) begin
    if (clr_en) begin
      mem[addr] <= '0;
    end else if (mac_en) begin
      mem[addr] <= upd;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int N     = 512,
  parameter int KAPPA = 23,
  parameter int IDX_W = 9,
  parameter int KW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             idx_valid,
  input  logic [IDX_W-1:0] idx_data,
  output logic             idx_ready,
  output logic             busy,
  output logic             done,
  output logic             clr_en,
  output logic             mac_en,
  output logic             acc_neg,
  output logic [IDX_W-1:0] sec_raddr,
  output logic [IDX_W-1:0] acc_addr
);

  localparam logic [IDX_W-1:0] POS_LAST = IDX_W'(N - 1);
  localparam logic [IDX_W:0]   N_EXT    = (IDX_W + 1)'(N);
  localparam logic [KW-1:0]    K_LAST   = KW'(KAPPA - 1);
  localparam bit               POW2     = (N == (1 << IDX_W));

  spm_state_e       state_q, state_d;
  logic [IDX_W-1:0] pos_q, pos_d;
  logic             pos_en;
  logic [IDX_W-1:0] shift_q, shift_d;
  logic             shift_en;
  logic [KW-1:0]    kcnt_q, kcnt_d;
  logic             kcnt_en;

  logic [IDX_W:0]   sum;
  logic             wrap;
  logic [IDX_W-1:0] folded;

  // next-state process
  always_comb begin
    state_d  = state_q;
    pos_d    = pos_q;
    pos_en   = 1'b0;
    shift_d  = shift_q;
    shift_en = 1'b0;
    kcnt_d   = kcnt_q;
    kcnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_CLEAR;
          pos_d   = '0;
          pos_en  = 1'b1;
          kcnt_d  = '0;
          kcnt_en = 1'b1;
        end
      end
      ST_CLEAR: begin
        pos_en = 1'b1;
        if (pos_q == POS_LAST) begin
          pos_d   = '0;
          state_d = ST_FETCH;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
      ST_FETCH: begin
        if (idx_valid) begin
          shift_d  = idx_data;
          shift_en = 1'b1;
          pos_d    = '0;
          pos_en   = 1'b1;
          state_d  = ST_MAC;
        end
      end
      ST_MAC: begin
        pos_en = 1'b1;
        if (pos_q == POS_LAST) begin
          pos_d   = '0;
          kcnt_d  = kcnt_q + 1'b1;
          kcnt_en = 1'b1;
          state_d = (kcnt_q == K_LAST) ? ST_DONE : ST_FETCH;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (shift_en) begin
      shift_q <= shift_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kcnt_q <= '0;
    end else if (kcnt_en) begin
      kcnt_q <= kcnt_d;
    end
  end

  // rotated target address and wrap flag
  assign sum = {1'b0, pos_q} + {1'b0, shift_q};

  generate
    if (POW2) begin : g_fold_pow2
      assign wrap   = sum[IDX_W];
      assign folded = sum[IDX_W-1:0];
    end else begin : g_fold_cmp
      assign wrap   = (sum >= N_EXT);
      assign folded = IDX_W'(wrap ? (sum - N_EXT) : sum);
    end
  endgenerate

  assign idx_ready = (state_q == ST_FETCH);
  assign busy      = (state_q == ST_CLEAR) || (state_q == ST_FETCH) || (state_q == ST_MAC);
  assign done      = (state_q == ST_DONE);
  assign clr_en    = (state_q == ST_CLEAR);
  assign mac_en    = (state_q == ST_MAC);
  assign acc_neg   = wrap;
  assign sec_raddr = pos_q;
  assign acc_addr  = clr_en ? pos_q : folded;

endmodule

// File: rtl/spm_negacyclic_mul.sv
module spm_negacyclic_mul
  import spm_pkg::*;
#(
  parameter  int N     = 512,
  parameter  int KAPPA = 23,
  parameter  int SEC_W = 4,
  localparam int IDX_W = $clog2(N),
  localparam int KW    = $clog2(KAPPA + 1),
  localparam int ACC_W = SEC_W + KW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sec_we,
  input  logic [IDX_W-1:0]        sec_waddr,
  input  logic signed [SEC_W-1:0] sec_wdata,
  input  logic                    start,
  input  logic                    idx_valid,
  input  logic [IDX_W-1:0]        idx_data,
  output logic                    idx_ready,
  output logic                    busy,
  output logic                    done,
  input  logic [IDX_W-1:0]        acc_raddr,
  output logic signed [ACC_W-1:0] acc_rdata
);

  logic                    clr_en;
  logic                    mac_en;
  logic                    acc_neg;
  logic [IDX_W-1:0]        sec_raddr;
  logic [IDX_W-1:0]        acc_addr;
  logic signed [SEC_W-1:0] sec_rdata;
  logic                    sec_wr_ok;

  // secret is frozen for the whole run
  assign sec_wr_ok = sec_we & ~busy;

  spm_ctrl #(
    .N    (N),
    .KAPPA(KAPPA),
    .IDX_W(IDX_W),
    .KW   (KW)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .idx_valid(idx_valid),
    .idx_data (idx_data),
    .idx_ready(idx_ready),
    .busy     (busy),
    .done     (done),
    .clr_en   (clr_en),
    .mac_en   (mac_en),
    .acc_neg  (acc_neg),
    .sec_raddr(sec_raddr),
    .acc_addr (acc_addr)
  );

  spm_sec_ram #(
    .N    (N),
    .IDX_W(IDX_W),
    .SEC_W(SEC_W)
  ) sec_i (
    .clk  (clk),
    .we   (sec_wr_ok),
    .waddr(sec_waddr),
    .wdata(sec_wdata),
    .raddr(sec_raddr),
    .rdata(sec_rdata)
  );

  spm_acc_bank #(
    .N    (N),
    .IDX_W(IDX_W),
    .SEC_W(SEC_W),
    .ACC_W(ACC_W)
  ) acc_i (
    .clk    (clk),
    .clr_en (clr_en),
    .mac_en (mac_en),
    .neg    (acc_neg),
    .addr   (acc_addr),
    .operand(sec_rdata),
    .raddr  (acc_raddr),
    .rdata  (acc_rdata)
  );

endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
  parameter int IDX_W = 9,
  parameter int ACC_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    idx_valid,
  input logic                    idx_ready,
  input logic                    busy,
  input logic                    done,
  input logic [IDX_W-1:0]        acc_raddr,
  input logic signed [ACC_W-1:0] acc_rdata
);

  // R1: no handshake offered outside a run
  a_r1_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> busy);

  // R6: done and busy never overlap
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2: start from rest launches a run
  a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R5: one position per pass, the pass follows at once
  a_r5_one_per_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && idx_ready) |=> (busy && !idx_ready));

  // R6: done holds until a new start
  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9: results frozen while done
  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!$stable(acc_raddr) || $stable(acc_rdata)));

endmodule

bind spm_negacyclic_mul spm_checker #(
  .IDX_W(IDX_W),
  .ACC_W(ACC_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .idx_valid(idx_valid),
  .idx_ready(idx_ready),
  .busy     (busy),
  .done     (done),
  .acc_raddr(acc_raddr),
  .acc_rdata(acc_rdata)
);

// File: tb/spm_negacyclic_mul_tb_top.sv
module spm_negacyclic_mul_tb_top;

  localparam int N     = 512;
  localparam int KAPPA = 23;
  localparam int SEC_W = 4;
  localparam int IDX_W = $clog2(N);
  localparam int ACC_W = SEC_W + $clog2(KAPPA + 1);
  localparam int LAT   = N + KAPPA * (N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_we = 1'b0;
  logic [IDX_W-1:0] sec_waddr = '0;
  logic signed [SEC_W-1:0] sec_wdata = '0;
  logic start = 1'b0;
  logic idx_valid = 1'b0;
  logic [IDX_W-1:0] idx_data = '0;
  logic idx_ready;
  logic busy;
  logic done;
  logic [IDX_W-1:0] acc_raddr = '0;
  logic signed [ACC_W-1:0] acc_rdata;

  int checks = 0;
  int fails  = 0;
  int sec_m [N];
  int exp_m [N];
  int idx_l [KAPPA];

  always #10 clk = ~clk;

  spm_negacyclic_mul #(.N(N), .KAPPA(KAPPA), .SEC_W(SEC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_we(sec_we), .sec_waddr(sec_waddr),
    .sec_wdata(sec_wdata), .start(start), .idx_valid(idx_valid),
    .idx_data(idx_data), .idx_ready(idx_ready), .busy(busy), .done(done),
    .acc_raddr(acc_raddr), .acc_rdata(acc_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic load_secret();
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      sec_we    = 1'b1;
      sec_waddr = IDX_W'(a);
      sec_wdata = SEC_W'(sec_m[a]);
    end
    @(negedge clk);
    sec_we = 1'b0;
  endtask

  // dense negacyclic schoolbook reference
  task automatic compute_expected();
    int cd [N];
    for (int m = 0; m < N; m++) cd[m] = 0;
    for (int k = 0; k < KAPPA; k++) cd[idx_l[k]]++;
    for (int m = 0; m < N; m++) exp_m[m] = 0;
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < N; m++) begin
        if (cd[m] != 0) begin
          if (i + m < N) exp_m[i + m] += cd[m] * sec_m[i];
          else           exp_m[i + m - N] -= cd[m] * sec_m[i];
        end
      end
    end
  endtask

  task automatic rand_secret(input int lo, input int hi);
    for (int a = 0; a < N; a++) sec_m[a] = lo + int'($urandom % (hi - lo + 1));
  endtask

  task automatic rand_indices();
    bit used [N];
    for (int m = 0; m < N; m++) used[m] = 1'b0;
    for (int k = 0; k < KAPPA; k++) begin
      int v;
      v = int'($urandom % N);
      while (used[v]) v = int'($urandom % N);
      used[v]  = 1'b1;
      idx_l[k] = v;
    end
  endtask

  // start a run, feed positions, return edges to done and positions taken
  task automatic run_mul(input bit stall, input bit disturb,
                         output int lat, output int taken);
    bit fire;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    lat   = 0;
    taken = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (done) break;
      idx_valid = stall ? ($urandom % 3 != 0) : 1'b1;
      idx_data  = (taken < KAPPA) ? IDX_W'(idx_l[taken]) : IDX_W'($urandom);
      if (disturb && lat == 1000) begin
        start     = 1'b1;
        sec_we    = 1'b1;
        sec_waddr = IDX_W'(7);
        sec_wdata = SEC_W'((sec_m[7] == 3) ? -3 : 3);
      end else begin
        sec_we = 1'b0;
      end
      fire = idx_valid && idx_ready;
      @(posedge clk);
      lat++;
      if (fire) taken++;
      if (lat > 4 * LAT) begin
        check(1'b0, "R6", "run did not finish", lat, LAT);
        break;
      end
    end
    sec_we = 1'b0;
    // R5: nothing more taken while done, with a position still offered
    for (int c = 0; c < 4; c++) begin
      idx_valid = 1'b1;
      #1;
      check(!idx_ready && done, "R5", "ready or done after run", int'(idx_ready), 0);
      @(negedge clk);
    end
    idx_valid = 1'b0;
  endtask

  task automatic read_compare(input string req);
    int bad;
    int first;
    bad   = 0;
    first = -1;
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      acc_raddr = IDX_W'(a);
      #1;
      if (int'(acc_rdata) != exp_m[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    end
    if (bad == 0) check(1'b1, req, "coefficients", 0, 0);
    else begin
      acc_raddr = IDX_W'(first);
      #1;
      check(1'b0, req, $sformatf("coefficient %0d", first), int'(acc_rdata), exp_m[first]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", "cycle limit reached", 190000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat;
    int taken;
    int keep0;
    int keep1;
    void'($urandom(32'd1234));

    // R1 reset state
    repeat (3) @(negedge clk);
    check(!busy && !done && !idx_ready, "R1", "outputs in reset", int'(busy | done | idx_ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy, "R1", "busy after reset", int'(busy), 0);
    check(!done && !idx_ready, "R1", "done/ready after reset", int'(done | idx_ready), 0);

    // R3/R6: random secret, distinct random positions
    rand_secret(-2, 2);
    load_secret();
    rand_indices();
    compute_expected();
    run_mul(1'b0, 1'b0, lat, taken);
    check(lat == LAT, "R6", "edges from start to done", lat, LAT);
    check(taken == KAPPA, "R5", "positions taken", taken, KAPPA);
    read_compare("R3");

    // R9: result held over idle cycles
    @(negedge clk); acc_raddr = '0; #1; keep0 = int'(acc_rdata);
    @(negedge clk); acc_raddr = IDX_W'(N - 1); #1; keep1 = int'(acc_rdata);
    repeat (20) @(negedge clk);
    acc_raddr = '0; #1;
    check(int'(acc_rdata) == exp_m[0] && keep0 == exp_m[0], "R9", "held coefficient 0", int'(acc_rdata), exp_m[0]);
    acc_raddr = IDX_W'(N - 1); #1;
    check(int'(acc_rdata) == exp_m[N-1] && keep1 == exp_m[N-1], "R9", "held top coefficient", int'(acc_rdata), exp_m[N-1]);

    // R2: rerun without reload, edge positions 0 and N-1 included
    rand_indices();
    idx_l[0] = 0;
    idx_l[1] = N - 1;
    for (int k = 2; k < KAPPA; k++) if (idx_l[k] == 0 || idx_l[k] == N - 1) idx_l[k] = 1 + k;
    compute_expected();
    run_mul(1'b0, 1'b0, lat, taken);
    read_compare("R2");

    // R4/R10: all terms at largest negative magnitude, same position repeated
    for (int a = 0; a < N; a++) sec_m[a] = -(1 << (SEC_W - 1));
    load_secret();
    for (int k = 0; k < KAPPA; k++) idx_l[k] = 0;
    compute_expected();
    run_mul(1'b0, 1'b0, lat, taken);
    read_compare("R4");
    acc_raddr = IDX_W'(5); #1;
    check(int'(acc_rdata) == -KAPPA * (1 << (SEC_W - 1)), "R10", "extreme negative sum", int'(acc_rdata), -KAPPA * (1 << (SEC_W - 1)));

    // R10: repeated top position, every wrapped term negated to positive
    for (int k = 0; k < KAPPA; k++) idx_l[k] = N - 1;
    compute_expected();
    run_mul(1'b0, 1'b0, lat, taken);
    read_compare("R10");

    // R7/R8: secret write and start during a run are ignored
    rand_secret(-4, 5);
    load_secret();
    rand_indices();
    compute_expected();
    run_mul(1'b0, 1'b1, lat, taken);
    check(lat == LAT, "R8", "latency with start while busy", lat, LAT);
    read_compare("R7");

    // R5: positions offered with gaps
    rand_indices();
    compute_expected();
    run_mul(1'b1, 1'b0, lat, taken);
    check(taken == KAPPA, "R5", "positions taken with gaps", taken, KAPPA);
    read_compare("R3");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule